// File: doc/BRIEF.md
# Packet Buffer Memory Arbiter

This block places one single-port memory of 512 words of 16 bits (1024 bytes) behind two independent requesters: a host bus port and a USB transfer engine port. Each side sees what looks like a private port. It raises a request with an address, write data, byte enables and a write flag. It holds that request until a one-cycle grant comes back. For a read, the word then arrives one cycle later with a valid strobe for that port only.

Memory cycles alternate between a host-preferred slot and a USB-reserved slot. The phase is fixed by reset. When both sides ask at once, the slot owner wins. A slot its owner leaves unused goes to the other side if that side is asking. As a result, the host can stream words back to back with no length limit while the USB engine is idle. It can keep streaming while a USB transfer is in progress and still take every other cycle. The USB side is never denied its own slot, so a serial transfer never starves.

Top module: `pktmem_arbiter`

## Requirements
- R1: While `rst` is high, neither grant is asserted whatever the requests, and both read-valid strobes are low in the cycle after reset is released. The first cycle after reset is a host-preferred slot.
- R2: In a host-preferred slot (even cycles counted from the release of reset, starting at 0), a host request is granted even when the USB side is requesting too.
- R3: In a USB-reserved slot (odd cycles counted from the release of reset), a USB request is granted even when the host side is requesting too.
- R4: A slot whose owner is not requesting is granted to the other port if that port is requesting, so a lone requester is granted in every cycle.
- R5: At most one grant is asserted in a cycle, and a grant is asserted only to a port that is requesting.
- R6: A granted read (write flag 0) gives that port's read-valid strobe, high for one cycle, in the cycle after the grant. The data is the addressed word. A granted write (write flag 1) raises no read-valid strobe, and the other port's strobe stays low.
- R7: Byte enable bit 0 controls data bits [7:0] and bit 1 controls bits [15:8]. A granted write changes only the enabled bytes of the addressed word.
- R8: When both ports hold requests continuously, neither port waits more than one cycle for a grant, and each port receives exactly half of the grants over any even number of cycles.
- R9: All 512 word addresses (0 to 511) are distinct and hold written data. Address 511 reads back what was last written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until granted |
| host_we | input | 1 | Host write flag (1 write, 0 read) |
| host_be | input | 2 | Host byte enables (bit 0 low byte) |
| host_addr | input | 9 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_gnt | output | 1 | Host grant, one cycle per access |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 16 | Host read data |
| usb_req | input | 1 | USB engine access request, held until granted |
| usb_we | input | 1 | USB write flag (1 write, 0 read) |
| usb_be | input | 2 | USB byte enables (bit 0 low byte) |
| usb_addr | input | 9 | USB word address |
| usb_wdata | input | 16 | USB write data |
| usb_gnt | output | 1 | USB grant, one cycle per access |
| usb_rvalid | output | 1 | USB read data valid |
| usb_rdata | output | 16 | USB read data |

## Verification
A cycle table drives every pairing of request patterns in both slot phases: both ports, host only, USB only, and neither, with mixed reads and writes. This separates slot ownership (R2, R3) from lending an idle slot (R4), and shows whether read strobes and data follow the granted port and not the requesting one. A continuous two-port stream checks the one-cycle wait bound and the even split of grants (R8). Directed partial writes at the top address check byte-lane isolation and the full address decode (R7, R9). A test that holds requests during reset shows that no grant leaks while `rst` is high.

// File: rtl/pktmem_pkg.sv
package pktmem_pkg;
  parameter int PM_DEPTH  = 512;
  parameter int PM_DATA_W = 16;

  typedef enum logic {
    SLOT_HOST = 1'b0,
    SLOT_USB  = 1'b1
  } slot_e;
endpackage

// File: rtl/pktmem_slot_sched.sv
module pktmem_slot_sched
  import pktmem_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  host_req,
  input  logic  usb_req,
  output logic  host_gnt,
  output logic  usb_gnt,
  output slot_e slot
);
  always_ff @(posedge clk) begin
    if (rst) slot <= SLOT_HOST;
    else     slot <= (slot == SLOT_HOST) ? SLOT_USB : SLOT_HOST;
  end

  // owner of the slot wins; an unused slot is lent to the other side
  always_comb begin
    host_gnt = 1'b0;
    usb_gnt  = 1'b0;
    if (!rst) begin
      if (slot == SLOT_HOST) begin
        host_gnt = host_req;
        usb_gnt  = usb_req & ~host_req;
      end else begin
        usb_gnt  = usb_req;
        host_gnt = host_req & ~usb_req;
      end
    end
  end
endmodule

// File: rtl/pktmem_port_mux.sv
module pktmem_port_mux #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              host_gnt,
  input  logic              host_we,
  input  logic [BE_W-1:0]   host_be,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              usb_gnt,
  input  logic              usb_we,
  input  logic [BE_W-1:0]   usb_be,
  input  logic [ADDR_W-1:0] usb_addr,
  input  logic [DATA_W-1:0] usb_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [BE_W-1:0]   mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  always_comb begin
    mem_en = host_gnt | usb_gnt;
    if (usb_gnt) begin
      mem_we    = usb_we;
      mem_be    = usb_be;
      mem_addr  = usb_addr;
      mem_wdata = usb_wdata;
    end else begin
      mem_we    = host_we;
      mem_be    = host_be;
      mem_addr  = host_addr;
      mem_wdata = host_wdata;
    end
  end
endmodule

// File: rtl/pktmem_spram.sv
module pktmem_spram #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [BE_W-1:0]   be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [BE_W-1:0][7:0] mem [DEPTH];
  logic [BE_W-1:0][7:0] lanes;

  genvar g;
  generate
    for (g = 0; g < BE_W; g++) begin : g_lane
      assign lanes[g] = wdata[g*8 +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int b = 0; b < BE_W; b++) begin
        if (be[b]) mem[addr][b] <= lanes[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && !we) rdata <= mem[addr];
  end
endmodule

// File: rtl/pktmem_rd_route.sv
module pktmem_rd_route (
  input  logic clk,
  input  logic rst,
  input  logic host_gnt,
  input  logic host_we,
  input  logic usb_gnt,
  input  logic usb_we,
  output logic host_rvalid,
  output logic usb_rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      usb_rvalid  <= 1'b0;
    end else begin
      host_rvalid <= host_gnt & ~host_we;
      usb_rvalid  <= usb_gnt & ~usb_we;
    end
  end
endmodule

// File: rtl/pktmem_arbiter.sv
module pktmem_arbiter
  import pktmem_pkg::*;
#(
  parameter int DEPTH  = PM_DEPTH,
  parameter int DATA_W = PM_DATA_W,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [BE_W-1:0]   host_be,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_gnt,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              usb_req,
  input  logic              usb_we,
  input  logic [BE_W-1:0]   usb_be,
  input  logic [ADDR_W-1:0] usb_addr,
  input  logic [DATA_W-1:0] usb_wdata,
  output logic              usb_gnt,
  output logic              usb_rvalid,
  output logic [DATA_W-1:0] usb_rdata
);
  slot_e             slot;
  logic              mem_en, mem_we;
  logic [BE_W-1:0]   mem_be;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  pktmem_slot_sched u_sched (
    .clk(clk), .rst(rst),
    .host_req(host_req), .usb_req(usb_req),
    .host_gnt(host_gnt), .usb_gnt(usb_gnt),
    .slot(slot)
  );

  pktmem_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .host_gnt(host_gnt), .host_we(host_we), .host_be(host_be),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .usb_gnt(usb_gnt), .usb_we(usb_we), .usb_be(usb_be),
    .usb_addr(usb_addr), .usb_wdata(usb_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  pktmem_spram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .en(mem_en), .we(mem_we), .be(mem_be),
    .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  pktmem_rd_route u_route (
    .clk(clk), .rst(rst),
    .host_gnt(host_gnt), .host_we(host_we),
    .usb_gnt(usb_gnt), .usb_we(usb_we),
    .host_rvalid(host_rvalid), .usb_rvalid(usb_rvalid)
  );

  assign host_rdata = mem_rdata;
  assign usb_rdata  = mem_rdata;
endmodule

// File: rtl/pktmem_arbiter_chk.sv
module pktmem_arbiter_chk
  import pktmem_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  host_req,
  input logic  host_we,
  input logic  host_gnt,
  input logic  host_rvalid,
  input logic  usb_req,
  input logic  usb_we,
  input logic  usb_gnt,
  input logic  usb_rvalid,
  input slot_e slot
);
  logic [1:0] host_wait, usb_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_wait <= '0;
      usb_wait  <= '0;
    end else begin
      host_wait <= (host_req && !host_gnt) ? host_wait + 2'd1 : 2'd0;
      usb_wait  <= (usb_req && !usb_gnt) ? usb_wait + 2'd1 : 2'd0;
    end
  end

  assert_no_grant_in_reset_R1: assert property (@(posedge clk)
    rst |-> (!host_gnt && !usb_gnt));

  assert_host_slot_owner_R2: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_HOST && host_req) |-> host_gnt);

  assert_usb_slot_owner_R3: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_USB && usb_req) |-> usb_gnt);

  assert_lend_to_host_R4: assert property (@(posedge clk) disable iff (rst)
    (host_req && !usb_req) |-> host_gnt);

  assert_lend_to_usb_R4: assert property (@(posedge clk) disable iff (rst)
    (usb_req && !host_req) |-> usb_gnt);

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
    !(host_gnt && usb_gnt));

  assert_grant_has_req_R5: assert property (@(posedge clk) disable iff (rst)
    (host_gnt |-> host_req) and (usb_gnt |-> usb_req));

  assert_host_rvalid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (host_gnt && !host_we) |=> host_rvalid);

  assert_usb_rvalid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (usb_gnt && !usb_we) |=> usb_rvalid);

  assert_rvalid_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({host_rvalid, usb_rvalid}));

  assert_host_wait_bound_R8: assert property (@(posedge clk) disable iff (rst)
    host_wait <= 2'd1);

  assert_usb_wait_bound_R8: assert property (@(posedge clk) disable iff (rst)
    usb_wait <= 2'd1);
endmodule

bind pktmem_arbiter pktmem_arbiter_chk u_chk (
  .clk(clk), .rst(rst),
  .host_req(host_req), .host_we(host_we), .host_gnt(host_gnt), .host_rvalid(host_rvalid),
  .usb_req(usb_req), .usb_we(usb_we), .usb_gnt(usb_gnt), .usb_rvalid(usb_rvalid),
  .slot(slot)
);

// File: tb/pktmem_arbiter_bench.sv
`timescale 1ns/1ps
module pktmem_arbiter_bench;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 0, host_we = 0, usb_req = 0, usb_we = 0;
  logic [1:0]  host_be = 2'b11, usb_be = 2'b11;
  logic [8:0]  host_addr = '0, usb_addr = '0;
  logic [15:0] host_wdata = '0, usb_wdata = '0;
  logic        host_gnt, host_rvalid, usb_gnt, usb_rvalid;
  logic [15:0] host_rdata, usb_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] model [DEPTH];
  bit          known [DEPTH];

  always #4 clk = ~clk;

  pktmem_arbiter u_pktmem_arbiter (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_be(host_be),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_gnt(host_gnt), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .usb_req(usb_req), .usb_we(usb_we), .usb_be(usb_be),
    .usb_addr(usb_addr), .usb_wdata(usb_wdata),
    .usb_gnt(usb_gnt), .usb_rvalid(usb_rvalid), .usb_rdata(usb_rdata)
  );

  // {host_req, host_we, usb_req, usb_we, exp_host_gnt, exp_usb_gnt}; even index = host slot
  localparam logic [5:0] VEC [16] = '{
    6'b111110, 6'b111101, 6'b110010, 6'b110010,
    6'b001101, 6'b001101, 6'b000000, 6'b101001,
    6'b101010, 6'b101101, 6'b111010, 6'b101001,
    6'b100010, 6'b001001, 6'b101010, 6'b000000
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [8:0] a, input logic [1:0] be, input logic [15:0] d);
    if (be[0]) model[a][7:0]  = d[7:0];
    if (be[1]) model[a][15:8] = d[15:8];
    known[a] = known[a] | (be == 2'b11);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic eh, eu, rh, ru;
    logic [15:0] exh, exu;
    int hw, uw, hg, ug;
    for (int k = 0; k < DEPTH; k++) known[k] = 0;

    // R1: requests held during reset are not granted
    host_req = 1; usb_req = 1;
    repeat (3) begin
      @(negedge clk); #1;
      check(!host_gnt && !usb_gnt, "R1 grant during reset", {host_gnt, usb_gnt}, 0);
    end
    @(negedge clk);
    rst = 0; host_req = 0; usb_req = 0;
    #1;
    check(!host_rvalid && !usb_rvalid, "R1 rvalid after reset", {host_rvalid, usb_rvalid}, 0);

    // table walk, cycle k after reset release
    for (int k = 0; k < 16; k++) begin
      if (k != 0) @(negedge clk);
      {host_req, host_we, usb_req, usb_we} = VEC[k][5:2];
      host_addr = 9'(k % 4);         host_wdata = 16'hA000 + 16'(k);
      usb_addr  = 9'(256 + (k % 4)); usb_wdata  = 16'h5000 + 16'(k);
      host_be = 2'b11; usb_be = 2'b11;
      eh = VEC[k][1]; eu = VEC[k][0];
      #1;
      check(host_gnt == eh, (k % 2 == 0) ? "R2 host grant" : "R4 host grant", host_gnt, eh);
      check(usb_gnt == eu,  (k % 2 == 1) ? "R3 usb grant" : "R4 usb grant", usb_gnt, eu);
      check(!(host_gnt && usb_gnt), "R5 single grant", {host_gnt, usb_gnt}, 0);
      rh = eh & ~host_we; ru = eu & ~usb_we;
      exh = model[host_addr]; exu = model[usb_addr];
      if (eh && host_we) model_write(host_addr, 2'b11, host_wdata);
      if (eu && usb_we)  model_write(usb_addr, 2'b11, usb_wdata);
      @(posedge clk); #1;
      check(host_rvalid == rh, "R6 host rvalid", host_rvalid, rh);
      check(usb_rvalid == ru,  "R6 usb rvalid", usb_rvalid, ru);
      if (rh && known[host_addr]) check(host_rdata == exh, "R6 host rdata", host_rdata, exh);
      if (ru && known[usb_addr])  check(usb_rdata == exu,  "R6 usb rdata", usb_rdata, exu);
    end

    // R8: continuous dual load
    @(negedge clk);
    host_req = 1; usb_req = 1; host_we = 0; usb_we = 0;
    hw = 0; uw = 0; hg = 0; ug = 0;
    for (int k = 0; k < 40; k++) begin
      host_addr = 9'(k); usb_addr = 9'(300 + k);
      #1;
      if (host_gnt) begin hg++; hw = 0; end else hw++;
      if (usb_gnt)  begin ug++; uw = 0; end else uw++;
      check(hw <= 1 && uw <= 1, "R8 wait bound", {hw[15:0], uw[15:0]}, 32'h00010001);
      @(negedge clk);
    end
    check(hg == 20, "R8 host share", hg, 20);
    check(ug == 20, "R8 usb share", ug, 20);
    host_req = 0; usb_req = 0;

    // R9 / R7: top address, byte lanes
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 9'd511; host_be = 2'b11; host_wdata = 16'h1234;
    #1; check(host_gnt, "R4 lone host write", host_gnt, 1);
    @(negedge clk);
    host_addr = 9'd0; host_wdata = 16'hBEEF;
    @(negedge clk);
    host_we = 0; host_addr = 9'd511;
    @(posedge clk); #1;
    check(host_rvalid && host_rdata == 16'h1234, "R9 top address", host_rdata, 16'h1234);
    @(negedge clk);
    host_we = 1; host_be = 2'b01; host_wdata = 16'hFFAB;
    @(negedge clk);
    host_we = 0;
    @(posedge clk); #1;
    check(host_rdata == 16'h12AB, "R7 low byte lane", host_rdata, 16'h12AB);
    @(negedge clk);
    host_req = 0;
    usb_req = 1; usb_we = 1; usb_be = 2'b10; usb_addr = 9'd511; usb_wdata = 16'hCD00;
    @(negedge clk);
    usb_we = 0;
    @(posedge clk); #1;
    check(usb_rvalid && !host_rvalid, "R6 usb strobe only", {host_rvalid, usb_rvalid}, 1);
    check(usb_rdata == 16'hCDAB, "R7 high byte lane", usb_rdata, 16'hCDAB);
    @(negedge clk);
    usb_req = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule